// File: doc/BRIEF.md
# PLL Divider Search Engine

This block finds the set of PLL divider values whose synthesized output frequency lands closest to a requested pixel clock. A caller presents a target frequency in hertz together with a flag that selects between two display classes (a low-voltage differential panel class and a general class), then pulses start. The engine walks a fixed nested sweep over the feedback and post-divider values. It evaluates one candidate at a time against every range limit, and it keeps the candidate with the smallest absolute frequency error.

When the sweep ends the engine raises done for one cycle. It then presents the chosen dividers, a valid flag, the resulting frequency, and two packed words ready for the PLL's divider register and control register. A single shared sequential divider computes both the VCO frequency (96 MHz reference times M, divided by N) and the output frequency (VCO divided by P). The VCO value is computed once per (N, M1, M2) combination and reused across the whole P1 loop.

Top module: `pll_div_search`

## Requirements
- R1: After reset, busy, done and valid are low, the tuple outputs read N=8, M1=20, M2=9, P1=8, P2=14, the frequency reads 0xFFFFFFFF, the divider word reads 0x00061207 and the control word reads 0x00800000.
- R2: A start pulse while idle raises busy from the next cycle. Busy stays high through the single cycle in which done is high. Both are low on the cycle after done.
- R3: A start pulse while busy has no effect: the running search completes with the result for the target and class captured at the accepted start.
- R4: A target above 400,000,000 Hz is rejected. Done rises on the cycle after start with valid low, and every divider output takes its range maximum (N=8, M1=20, M2=9, P1=8, P2=14, frequency 0xFFFFFFFF). The same maxima appear whenever no candidate passes. A target of exactly 400,000,000 Hz is searched normally.
- R5: The reported frequency equals floor(floor(96,000,000 * (5*M1 + M2) / N) / (P1*P2)) for the reported tuple.
- R6: A valid result satisfies N in 3..8, M1 in 10..20, M2 in 5..min(9, M1), P1 in 1..8, M = 5*M1+M2 in 70..120, and VCO in 1.4..2.8 GHz inclusive. P = P1*P2 must lie in 7..98 for the panel class (lvds_i=1) and in 5..80 for the general class.
- R7: P2 is 14 for the panel class when the target is at most 112 MHz and 7 above it. For the general class it is 10 when the target is at most 200 MHz and 5 above it.
- R8: The chosen tuple minimizes the absolute error to the target. The sweep runs N upward from 3, then M1 downward from 20 to 10, then M2 downward from min(9, M1) to 5, then P1 downward from 8 to 1, nested in that order. A later candidate replaces the stored one only on strictly smaller error, so the first candidate in that order wins a tie.
- R9: The divider word holds N-2 in bits 23:16, M1-2 in bits 15:8 and M2-2 in bits 7:0, with all other bits zero.
- R10: The control word holds P1 one-hot as bit (15 + P1), so bits 23:16 carry 1 << (P1-1). Bit 24 is set when P2 is 5 or 7 and clear when P2 is 10 or 14. All other bits are zero.
- R11: All result outputs hold their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| lvds_i | input | 1 | 1 selects the panel limit class, 0 the general class |
| target_hz_i | input | 32 | Requested output frequency in Hz |
| busy_o | output | 1 | Search in progress, including the done cycle |
| done_o | output | 1 | One-cycle completion pulse |
| valid_o | output | 1 | A candidate was found |
| n_o | output | 4 | Chosen N |
| m1_o | output | 5 | Chosen M1 |
| m2_o | output | 4 | Chosen M2 |
| p1_o | output | 4 | Chosen P1 |
| p2_o | output | 4 | Chosen P2 |
| freq_hz_o | output | 32 | Resulting output frequency in Hz |
| div_word_o | output | 32 | Packed divider register word |
| ctl_word_o | output | 32 | Packed control register word |

## Verification
The hardest behaviour to expose is the tie rule. Many tuples yield the same truncated frequency, and a replace-on-equal design differs only in which of several equally good tuples it reports. The bench therefore compares all five divider values against an arithmetic sweep in the same order, across targets on both sides of each P2 threshold and in both classes. A start pulse inside a running search is reached by waiting a couple of hundred cycles after an accepted start and then driving a different target and class. The no-candidate path cannot occur with these fixed limits, so the maxima it produces are exercised through the over-range rejection, which shares the same output loading.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;
  localparam int unsigned N_W    = 4;
  localparam int unsigned M1_W   = 5;
  localparam int unsigned M2_W   = 4;
  localparam int unsigned P1_W   = 4;
  localparam int unsigned P2_W   = 4;
  localparam int unsigned M_W    = 7;
  localparam int unsigned P_W    = 7;
  localparam int unsigned FREQ_W = 32;
  localparam int unsigned DIV_W  = 34;  // ref*M_max needs 34 bits
  localparam int unsigned P1_CNT = 8;

  localparam logic [N_W-1:0]    N_LO   = 4'd3;
  localparam logic [N_W-1:0]    N_HI   = 4'd8;
  localparam logic [M1_W-1:0]   M1_LO  = 5'd10;
  localparam logic [M1_W-1:0]   M1_HI  = 5'd20;
  localparam logic [M2_W-1:0]   M2_LO  = 4'd5;
  localparam logic [M2_W-1:0]   M2_HI  = 4'd9;
  localparam logic [P1_W-1:0]   P1_LO  = 4'd1;
  localparam logic [P1_W-1:0]   P1_HI  = 4'd8;
  localparam logic [P2_W-1:0]   P2_MAX = 4'd14;
  localparam logic [M_W-1:0]    M_LO   = 7'd70;
  localparam logic [M_W-1:0]    M_HI   = 7'd120;
  localparam logic [DIV_W-1:0]  REF_HZ = 34'd96_000_000;
  localparam logic [DIV_W-1:0]  VCO_LO = 34'd1_400_000_000;
  localparam logic [DIV_W-1:0]  VCO_HI = 34'd2_800_000_000;
  localparam logic [FREQ_W-1:0] FMAX_HZ = 32'd400_000_000;

  typedef struct packed {
    logic [P_W-1:0]    p_lo;
    logic [P_W-1:0]    p_hi;
    logic [P2_W-1:0]   p2_slow;
    logic [P2_W-1:0]   p2_fast;
    logic [FREQ_W-1:0] thr;
  } lim_t;

  typedef struct packed {
    logic [N_W-1:0]    n;
    logic [M1_W-1:0]   m1;
    logic [M2_W-1:0]   m2;
    logic [P1_W-1:0]   p1;
    logic [P2_W-1:0]   p2;
    logic [FREQ_W-1:0] freq;
  } best_t;

  localparam best_t BEST_MAX = '{n: N_HI, m1: M1_HI, m2: M2_HI, p1: P1_HI,
                                 p2: P2_MAX, freq: '1};

  typedef enum logic [2:0] {
    S_IDLE, S_CHK_M, S_VCO, S_CHK_P, S_PDIV, S_NXT_P, S_NXT_M, S_DONE
  } st_e;

  function automatic lim_t class_lim(input logic panel);
    lim_t l;
    if (panel) l = '{p_lo: 7'd7, p_hi: 7'd98, p2_slow: 4'd14, p2_fast: 4'd7,
                     thr: 32'd112_000_000};
    else       l = '{p_lo: 7'd5, p_hi: 7'd80, p2_slow: 4'd10, p2_fast: 4'd5,
                     thr: 32'd200_000_000};
    return l;
  endfunction

  function automatic logic [M2_W-1:0] m2_start(input logic [M1_W-1:0] m1);
    return (m1 < M1_W'(M2_HI)) ? M2_W'(m1) : M2_HI;
  endfunction
endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int unsigned W         = 34,
  parameter int unsigned STEP_BITS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] q_o,
  output logic         done_o
);
  localparam int unsigned STEPS = (W + STEP_BITS - 1) / STEP_BITS;
  localparam int unsigned PW    = STEPS * STEP_BITS;
  localparam int unsigned CW    = $clog2(STEPS + 1);

  logic [PW-1:0] sh_q, sh_c;
  logic [W:0]    rem_q, rem_c;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  // STEP_BITS restoring iterations per clock; quotient shifts in behind dividend
  always_comb begin
    rem_c = rem_q;
    sh_c  = sh_q;
    for (int k = 0; k < STEP_BITS; k++) begin
      rem_c = {rem_c[W-1:0], sh_c[PW-1]};
      sh_c  = {sh_c[PW-2:0], 1'b0};
      if (rem_c >= {1'b0, dvs_q}) begin
        rem_c   = rem_c - {1'b0, dvs_q};
        sh_c[0] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      sh_q   <= PW'(a_i);
      rem_q  <= '0;
      dvs_q  <= b_i;
      cnt_q  <= CW'(STEPS);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      sh_q   <= sh_c;
      rem_q  <= rem_c;
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign q_o    = sh_q[W-1:0];
  assign done_o = done_q;
endmodule

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_srch_pkg::*;
(
  input  logic [N_W-1:0]  n_i,
  input  logic [M1_W-1:0] m1_i,
  input  logic [M2_W-1:0] m2_i,
  input  logic [P1_W-1:0] p1_i,
  input  logic [P2_W-1:0] p2_i,
  output logic [31:0]     div_word_o,
  output logic [31:0]     ctl_word_o
);
  localparam int unsigned FLD_W  = 8;
  localparam int unsigned P1_SH  = 16;
  localparam int unsigned P2_BIT = 24;

  logic [P1_CNT-1:0] p1_oh;

  for (genvar g = 0; g < P1_CNT; g++) begin : g_p1_oh
    assign p1_oh[g] = (p1_i == P1_W'(g + 1));
  end

  assign div_word_o = {FLD_W'(0),
                       FLD_W'(n_i)  - FLD_W'(2),
                       FLD_W'(m1_i) - FLD_W'(2),
                       FLD_W'(m2_i) - FLD_W'(2)};

  always_comb begin
    ctl_word_o                      = '0;
    ctl_word_o[P1_SH +: P1_CNT]     = p1_oh;
    ctl_word_o[P2_BIT]              = (p2_i == 4'd5) || (p2_i == 4'd7);
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_srch_pkg::*;
#(
  parameter int unsigned STEP_BITS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              lvds_i,
  input  logic [FREQ_W-1:0] target_hz_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              valid_o,
  output logic [N_W-1:0]    n_o,
  output logic [M1_W-1:0]   m1_o,
  output logic [M2_W-1:0]   m2_o,
  output logic [P1_W-1:0]   p1_o,
  output logic [P2_W-1:0]   p2_o,
  output logic [FREQ_W-1:0] freq_hz_o,
  output logic [31:0]       div_word_o,
  output logic [31:0]       ctl_word_o
);
  st_e               st_q;
  logic [N_W-1:0]    n_q;
  logic [M1_W-1:0]   m1_q;
  logic [M2_W-1:0]   m2_q;
  logic [P1_W-1:0]   p1_q;
  logic [P2_W-1:0]   p2_q;
  logic [P_W-1:0]    plo_q, phi_q;
  logic [FREQ_W-1:0] tgt_q, err_q;
  logic [DIV_W-1:0]  vco_q;
  logic              found_q;
  best_t             best_q;

  lim_t              lim_in;
  logic [M_W-1:0]    m_val;
  logic [P_W-1:0]    p_val;
  logic              m_ok, p_ok, vco_ok, last_m, better;
  logic              div_start, div_done;
  logic [DIV_W-1:0]  div_a, div_b, div_q;
  logic [FREQ_W-1:0] freq_c, err_c;

  assign lim_in = class_lim(lvds_i);
  assign m_val  = M_W'(5) * M_W'(m1_q) + M_W'(m2_q);
  assign p_val  = P_W'(p1_q) * P_W'(p2_q);
  assign m_ok   = (m_val >= M_LO) && (m_val <= M_HI);
  assign p_ok   = (p_val >= plo_q) && (p_val <= phi_q);
  assign vco_ok = (div_q >= VCO_LO) && (div_q <= VCO_HI);
  assign last_m = (m2_q == M2_LO) && (m1_q == M1_LO) && (n_q == N_HI);
  assign freq_c = div_q[FREQ_W-1:0];
  assign err_c  = (freq_c > tgt_q) ? freq_c - tgt_q : tgt_q - freq_c;
  assign better = err_c < err_q;

  // one divider serves both the VCO step and the output step
  assign div_start = ((st_q == S_CHK_M) && m_ok) || ((st_q == S_CHK_P) && p_ok);
  assign div_a     = (st_q == S_CHK_M) ? REF_HZ * DIV_W'(m_val) : vco_q;
  assign div_b     = (st_q == S_CHK_M) ? DIV_W'(n_q) : DIV_W'(p_val);

  pll_seq_div #(.W(DIV_W), .STEP_BITS(STEP_BITS)) u_div (
    .clk_i, .rst_ni,
    .start_i (div_start),
    .a_i     (div_a),
    .b_i     (div_b),
    .q_o     (div_q),
    .done_o  (div_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      n_q     <= N_LO;
      m1_q    <= M1_HI;
      m2_q    <= M2_HI;
      p1_q    <= P1_HI;
      p2_q    <= P2_MAX;
      plo_q   <= '0;
      phi_q   <= '0;
      tgt_q   <= '0;
      err_q   <= '1;
      vco_q   <= '0;
      found_q <= 1'b0;
      best_q  <= BEST_MAX;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          tgt_q   <= target_hz_i;
          plo_q   <= lim_in.p_lo;
          phi_q   <= lim_in.p_hi;
          p2_q    <= (target_hz_i <= lim_in.thr) ? lim_in.p2_slow : lim_in.p2_fast;
          found_q <= 1'b0;
          err_q   <= '1;
          n_q     <= N_LO;
          m1_q    <= M1_HI;
          m2_q    <= m2_start(M1_HI);
          p1_q    <= P1_HI;
          if (target_hz_i > FMAX_HZ) begin
            best_q <= BEST_MAX;
            st_q   <= S_DONE;
          end else begin
            st_q   <= S_CHK_M;
          end
        end
        S_CHK_M: st_q <= m_ok ? S_VCO : S_NXT_M;
        S_VCO: if (div_done) begin
          vco_q <= div_q;
          p1_q  <= P1_HI;
          st_q  <= vco_ok ? S_CHK_P : S_NXT_M;
        end
        S_CHK_P: st_q <= p_ok ? S_PDIV : S_NXT_P;
        S_PDIV: if (div_done) begin
          if (better) begin
            err_q   <= err_c;
            found_q <= 1'b1;
            best_q  <= '{n: n_q, m1: m1_q, m2: m2_q, p1: p1_q, p2: p2_q, freq: freq_c};
          end
          st_q <= S_NXT_P;
        end
        S_NXT_P: begin
          if (p1_q == P1_LO) st_q <= S_NXT_M;
          else begin
            p1_q <= p1_q - 1'b1;
            st_q <= S_CHK_P;
          end
        end
        S_NXT_M: begin
          if (last_m) begin
            if (!found_q) best_q <= BEST_MAX;
            st_q <= S_DONE;
          end else begin
            st_q <= S_CHK_M;
            if (m2_q != M2_LO) m2_q <= m2_q - 1'b1;
            else if (m1_q != M1_LO) begin
              m1_q <= m1_q - 1'b1;
              m2_q <= m2_start(m1_q - 1'b1);
            end else begin
              n_q  <= n_q + 1'b1;
              m1_q <= M1_HI;
              m2_q <= m2_start(M1_HI);
            end
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != S_IDLE);
  assign done_o    = (st_q == S_DONE);
  assign valid_o   = found_q;
  assign n_o       = best_q.n;
  assign m1_o      = best_q.m1;
  assign m2_o      = best_q.m2;
  assign p1_o      = best_q.p1;
  assign p2_o      = best_q.p2;
  assign freq_hz_o = best_q.freq;

  pll_word_pack u_pack (
    .n_i        (best_q.n),
    .m1_i       (best_q.m1),
    .m2_i       (best_q.m2),
    .p1_i       (best_q.p1),
    .p2_i       (best_q.p2),
    .div_word_o (div_word_o),
    .ctl_word_o (ctl_word_o)
  );
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk
  import pll_srch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FREQ_W-1:0] target_hz_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              valid_o,
  input logic [N_W-1:0]    n_o,
  input logic [M1_W-1:0]   m1_o,
  input logic [M2_W-1:0]   m2_o,
  input logic [P1_W-1:0]   p1_o,
  input logic [P2_W-1:0]   p2_o,
  input logic [FREQ_W-1:0] freq_hz_o,
  input logic [31:0]       ctl_word_o
);
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r4_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && (target_hz_i > FMAX_HZ)) |=>
      (done_o && !valid_o && n_o == N_HI && m1_o == M1_HI && m2_o == M2_HI &&
       p1_o == P1_HI && p2_o == P2_MAX && freq_hz_o == '1));

  a_r6_tuple_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |->
      (n_o >= N_LO && n_o <= N_HI && m1_o >= M1_LO && m1_o <= M1_HI &&
       m2_o >= M2_LO && m2_o <= M2_HI && M1_W'(m2_o) <= m1_o &&
       p1_o >= P1_LO && p1_o <= P1_HI));

  a_r10_ctl_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(ctl_word_o[23:16]) == 1 &&
                (p2_o == 4'd5 || p2_o == 4'd7 || p2_o == 4'd10 || p2_o == 4'd14)));

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i)) |->
      ($stable(freq_hz_o) && $stable(n_o) && $stable(m1_o) && $stable(m2_o) &&
       $stable(p1_o) && $stable(p2_o) && $stable(valid_o)));
endmodule

bind pll_div_search pll_div_search_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .target_hz_i (target_hz_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .valid_o     (valid_o),
  .n_o         (n_o),
  .m1_o        (m1_o),
  .m2_o        (m2_o),
  .p1_o        (p1_o),
  .p2_o        (p2_o),
  .freq_hz_o   (freq_hz_o),
  .ctl_word_o  (ctl_word_o)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        lvds_i = 1'b0;
  logic [31:0] target_hz_i = '0;
  logic        busy_o, done_o, valid_o;
  logic [3:0]  n_o, m2_o, p1_o, p2_o;
  logic [4:0]  m1_o;
  logic [31:0] freq_hz_o, div_word_o, ctl_word_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pll_div_search u_dut (
    .clk_i, .rst_ni, .start_i, .lvds_i, .target_hz_i,
    .busy_o, .done_o, .valid_o, .n_o, .m1_o, .m2_o, .p1_o, .p2_o,
    .freq_hz_o, .div_word_o, .ctl_word_o
  );

  typedef struct {
    int     n, m1, m2, p1, p2;
    longint f;
    bit     ok;
  } exp_t;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input bit panel, input longint tgt);
    exp_t   e;
    longint best, m, p, vco, f, err;
    int     plo, phi, p2;
    e = '{n: 8, m1: 20, m2: 9, p1: 8, p2: 14, f: 64'hFFFF_FFFF, ok: 1'b0};
    if (tgt > 400_000_000) return e;
    plo  = panel ? 7 : 5;
    phi  = panel ? 98 : 80;
    p2   = panel ? ((tgt <= 112_000_000) ? 14 : 7) : ((tgt <= 200_000_000) ? 10 : 5);
    best = 64'h7FFF_FFFF_FFFF_FFFF;
    for (int n = 3; n <= 8; n++)
      for (int m1 = 20; m1 >= 10; m1--)
        for (int m2 = (m1 < 9 ? m1 : 9); m2 >= 5; m2--)
          for (int p1 = 8; p1 >= 1; p1--) begin
            m   = 5 * m1 + m2;
            p   = p1 * p2;
            vco = (64'd96_000_000 * m) / n;
            f   = vco / p;
            if (m >= 70 && m <= 120 && p >= plo && p <= phi &&
                vco >= 64'd1_400_000_000 && vco <= 64'd2_800_000_000) begin
              err = (f > tgt) ? f - tgt : tgt - f;
              if (err < best) begin
                best = err;
                e = '{n: n, m1: m1, m2: m2, p1: p1, p2: p2, f: f, ok: 1'b1};
              end
            end
          end
    return e;
  endfunction

  task automatic check_result(input bit panel, input longint tgt);
    exp_t   e;
    longint m, p, vco, f2, dw, cw;
    bit     inr;
    e = model(panel, tgt);
    chk("R4 valid", valid_o, e.ok);
    chk("R8 n", n_o, e.n);
    chk("R8 m1", m1_o, e.m1);
    chk("R8 m2", m2_o, e.m2);
    chk("R8 p1", p1_o, e.p1);
    chk("R7 p2", p2_o, e.p2);
    chk("R8 freq", freq_hz_o, e.f);
    if (e.ok) begin
      m   = 5 * m1_o + m2_o;
      p   = p1_o * p2_o;
      vco = (64'd96_000_000 * m) / n_o;
      f2  = vco / p;
      chk("R5 freq equation", freq_hz_o, f2);
      inr = (n_o >= 3 && n_o <= 8 && m1_o >= 10 && m1_o <= 20 && m2_o >= 5 &&
             m2_o <= 9 && m2_o <= m1_o && p1_o >= 1 && p1_o <= 8 && m >= 70 && m <= 120 &&
             vco >= 64'd1_400_000_000 && vco <= 64'd2_800_000_000 &&
             p >= (panel ? 7 : 5) && p <= (panel ? 98 : 80));
      chk("R6 limits", inr, 1);
    end
    dw = ((e.n - 2) << 16) | ((e.m1 - 2) << 8) | (e.m2 - 2);
    cw = (64'd1 << (e.p1 + 15)) | ((e.p2 == 5 || e.p2 == 7) ? (64'd1 << 24) : 0);
    chk("R9 divider word", div_word_o, dw);
    chk("R10 control word", ctl_word_o, cw);
  endtask

  task automatic run(input bit panel, input longint tgt, input bit interfere);
    logic [31:0] f_done;
    logic [3:0]  n_done;
    @(negedge clk_i);
    lvds_i      = panel;
    target_hz_i = 32'(tgt);
    start_i     = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy after start", busy_o, 1);
    if (tgt > 400_000_000) chk("R4 done next cycle", done_o, 1);
    if (interfere) begin
      repeat (200) @(negedge clk_i);
      chk("R3 still busy", busy_o, 1);
      lvds_i      = ~panel;
      target_hz_i = 32'd148_500_000;
      start_i     = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    chk("R2 busy with done", busy_o, 1);
    check_result(panel, tgt);
    f_done = freq_hz_o;
    n_done = n_o;
    @(negedge clk_i);
    chk("R2 done one cycle", done_o, 0);
    chk("R2 idle after done", busy_o, 0);
    repeat (5) @(negedge clk_i);
    chk("R11 freq held", freq_hz_o, f_done);
    chk("R11 n held", n_o, n_done);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 valid", valid_o, 0);
    chk("R1 n", n_o, 8);
    chk("R1 m1", m1_o, 20);
    chk("R1 m2", m2_o, 9);
    chk("R1 p1", p1_o, 8);
    chk("R1 p2", p2_o, 14);
    chk("R1 freq", freq_hz_o, 64'hFFFF_FFFF);
    chk("R1 divider word", div_word_o, 64'h0006_1207);
    chk("R1 control word", ctl_word_o, 64'h0080_0000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(1'b0, 400_000_001, 1'b0);   // R4 reject
    run(1'b1, 65_000_000, 1'b0);
    run(1'b1, 112_000_000, 1'b0);   // R7 panel threshold, slow side
    run(1'b1, 150_000_000, 1'b0);
    run(1'b0, 25_175_000, 1'b0);
    run(1'b0, 200_000_000, 1'b0);   // R7 general threshold, slow side
    run(1'b0, 400_000_000, 1'b0);   // R4 boundary accepted
    run(1'b1, 83_500_000, 1'b1);    // R3 start while busy
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195_000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule